// File: doc/BRIEF.md
# TDM Time Slot Assigner

The block sits between a serial time-division-multiplexed highway and one serial channel. A bit counter is re-aligned by a frame sync pulse, and the counter position is compared against a programmed start bit time and stop bit time. The bits that fall inside that window are handed to the channel, and the channel's own transmit bits are placed onto the highway in the same positions. The window is set to the bit, not to the byte, so it can cover one bit, a few bits inside one 8-bit slot (for example D-channel data), several slots, or the whole frame.

The clock is the highway bit clock. In the cycle the counter reads N, the highway carries bit N of the frame. Outside the window the transmit enable is low, so other assigners can drive the same shared line. The start and stop fields can be rewritten at any time. They are copied into working registers only on a frame sync edge, so a frame never sees a window that is half old and half new. If sync stops arriving, the counter stops at its last position and the window stays closed until the next sync.

Top module: `tdm_slot_assigner`

## Requirements
- R1: On a clock edge where `fsync_i` is sampled high, the bit position becomes 0. On each later edge without sync it advances by one, so the cycle that follows the k-th edge after the sync edge carries bit k.
- R2: `win_o` and `txd_oe_o` are high in the cycle that carries bit N exactly when start ≤ N ≤ stop. Both bounds are inclusive.
- R3: When the working start value is greater than the working stop value, no bit of the frame is selected.
- R4: One cycle after every in-window bit, `rx_strobe_o` is high and `rx_data_o` holds the value `rxd_i` had at the closing edge of that bit. After an out-of-window bit, `rx_strobe_o` is low.
- R5: During the window, `txd_o` follows `tx_data_i`. Outside the window, `txd_o` is 1 and `txd_oe_o` is 0.
- R6: `cfg_start_i` and `cfg_stop_i` are used only on a sync edge. Changes to them during a frame have no effect until the next sync.
- R7: Without a sync, the position stops at 2^CNT_W−1. After that bit, no window and no strobe occur until a sync is seen.
- R8: After reset, and until the first sync, `win_o`, `txd_oe_o` and `rx_strobe_o` stay low.
- R9: A frame may be any length up to 2^CNT_W bits. A sync that arrives early restarts the count and cuts the old window short.
- R10: The window may start and stop inside a single 8-bit slot, selecting from one to eight of its bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Highway bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync_i | input | 1 | Frame sync, sampled on the clock edge |
| rxd_i | input | 1 | Serial receive data from the highway |
| txd_o | output | 1 | Serial transmit data to the highway |
| txd_oe_o | output | 1 | Transmit drive enable; low means the line is released |
| cfg_start_i | input | CNT_W | First bit time of the window, counted from sync |
| cfg_stop_i | input | CNT_W | Last bit time of the window, counted from sync |
| tx_data_i | input | 1 | Channel transmit bit for the current position |
| rx_data_o | output | 1 | Captured receive bit for the channel |
| rx_strobe_o | output | 1 | One-cycle strobe marking a valid `rx_data_o` |
| win_o | output | 1 | Window-active flag for the current bit |

## Verification
The bench builds the block with 8-bit slots and 4 slots, which gives a 5-bit counter and a 32-bit frame. At that size every start/stop pair, all 1024 of them, can be swept one frame each, with random values on the config inputs during every non-sync cycle. This covers each empty window, each single-bit window and each window held inside a slot. The small counter also makes saturation and early sync cheap to reach: a long run without sync passes the last position quickly, and short frames cut a window in mid-flight.

// File: rtl/tsa_pkg.sv
// Package: shared constants and helpers for the time slot assigner.
// Assumes: nothing beyond IEEE 1800-2017.
package tsa_pkg;

    // Level driven on the transmit line while the window is closed.
    localparam logic TX_IDLE_LEVEL = 1'b1;

    // Counter width needed to index every bit of a frame.
    function automatic int frame_cnt_width(input int slot_bits, input int slots);
        return $clog2(slot_bits * slots);
    endfunction

    // Inclusive window membership test.
    function automatic logic pos_in_window(input int unsigned pos,
                                           input int unsigned first,
                                           input int unsigned last);
        return (pos >= first) && (pos <= last);
    endfunction

endpackage

// File: rtl/tsa_bit_counter.sv
// Module: frame bit position counter.
// Assumes: fsync_i is sampled on the clock edge and marks bit 0 of the next cycle.
// The counter clears on sync, advances once per bit, and holds at its top value.
// live_o drops once the top position has passed without a new sync.
module tsa_bit_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync_i,
    output logic [CNT_W-1:0] pos_o,
    output logic             live_o
);
    localparam logic [CNT_W-1:0] POS_MAX = '1;

    // Track position in frame, clear on sync, saturate without sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_o  <= POS_MAX;
            live_o <= 1'b0;
        end else if (fsync_i) begin
            pos_o  <= '0;
            live_o <= 1'b1;
        end else if (pos_o == POS_MAX) begin
            live_o <= 1'b0;
        end else begin
            pos_o  <= pos_o + 1'b1;
        end
    end
endmodule

// File: rtl/tsa_cfg_shadow.sv
// Module: working copy of the window bounds.
// Assumes: the programmed fields may change at any time. They are copied only on load_i (sync).
// On reset the window is empty (start at top, stop at zero).
module tsa_cfg_shadow #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] start_i,
    input  logic [CNT_W-1:0] stop_i,
    output logic [CNT_W-1:0] start_o,
    output logic [CNT_W-1:0] stop_o
);
    // Copy the programmed bounds at frame sync only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_o <= '1;
            stop_o  <= '0;
        end else if (load_i) begin
            start_o <= start_i;
            stop_o  <= stop_i;
        end
    end
endmodule

// File: rtl/tsa_window_decode.sv
// Module: window decision and transmit line control.
// Assumes: pos_i is the bit currently on the highway and live_i qualifies it.
// Purely combinational. The transmit line idles at TX_IDLE_LEVEL when released.
module tsa_window_decode
    import tsa_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic [CNT_W-1:0] pos_i,
    input  logic             live_i,
    input  logic [CNT_W-1:0] start_i,
    input  logic [CNT_W-1:0] stop_i,
    input  logic             tx_bit_i,
    output logic             win_o,
    output logic             txd_o,
    output logic             txd_oe_o
);
    // Decide window membership for the current bit.
    always_comb begin
        win_o = live_i && pos_in_window(32'(pos_i), 32'(start_i), 32'(stop_i));
    end

    // Drive or release the shared transmit line.
    always_comb begin
        txd_oe_o = win_o;
        txd_o    = win_o ? tx_bit_i : TX_IDLE_LEVEL;
    end
endmodule

// File: rtl/tsa_rx_capture.sv
// Module: receive bit capture for the channel.
// Assumes: win_i marks that the bit on rxd_i belongs to the channel.
// Produces the bit and a strobe one cycle after the in-window bit.
module tsa_rx_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic win_i,
    input  logic rxd_i,
    output logic data_o,
    output logic strobe_o
);
    // Register in-window receive bits and flag them for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o   <= 1'b0;
            strobe_o <= 1'b0;
        end else begin
            strobe_o <= win_i;
            if (win_i) begin
                data_o <= rxd_i;
            end
        end
    end
endmodule

// File: rtl/tdm_slot_assigner.sv
// Module: top of the TDM time slot assigner.
// Assumes: clk is the highway bit clock and fsync_i is a single-cycle sync pulse.
// Frame length up to SLOT_W*NUM_SLOTS bits. Window bounds are bit positions from sync.
module tdm_slot_assigner
    import tsa_pkg::*;
#(
    parameter  int SLOT_W    = 8,
    parameter  int NUM_SLOTS = 512,
    localparam int CNT_W     = frame_cnt_width(SLOT_W, NUM_SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync_i,
    input  logic             rxd_i,
    output logic             txd_o,
    output logic             txd_oe_o,
    input  logic [CNT_W-1:0] cfg_start_i,
    input  logic [CNT_W-1:0] cfg_stop_i,
    input  logic             tx_data_i,
    output logic             rx_data_o,
    output logic             rx_strobe_o,
    output logic             win_o
);
    logic [CNT_W-1:0] bit_pos;
    logic             pos_live;
    logic [CNT_W-1:0] act_start;
    logic [CNT_W-1:0] act_stop;

    tsa_bit_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .fsync_i (fsync_i),
        .pos_o   (bit_pos),
        .live_o  (pos_live)
    );

    tsa_cfg_shadow #(.CNT_W(CNT_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (fsync_i),
        .start_i (cfg_start_i),
        .stop_i  (cfg_stop_i),
        .start_o (act_start),
        .stop_o  (act_stop)
    );

    tsa_window_decode #(.CNT_W(CNT_W)) u_win (
        .pos_i    (bit_pos),
        .live_i   (pos_live),
        .start_i  (act_start),
        .stop_i   (act_stop),
        .tx_bit_i (tx_data_i),
        .win_o    (win_o),
        .txd_o    (txd_o),
        .txd_oe_o (txd_oe_o)
    );

    tsa_rx_capture u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_i    (win_o),
        .rxd_i    (rxd_i),
        .data_o   (rx_data_o),
        .strobe_o (rx_strobe_o)
    );
endmodule

// File: rtl/tsa_checker.sv
// Module: protocol checker for tdm_slot_assigner, bound to every instance.
// Assumes: synchronous active-low reset; all properties are disabled during reset.
module tsa_checker #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fsync_i,
    input logic             rxd_i,
    input logic             txd_o,
    input logic             win_o,
    input logic             rx_data_o,
    input logic             rx_strobe_o,
    input logic [CNT_W-1:0] bit_pos,
    input logic [CNT_W-1:0] act_start,
    input logic [CNT_W-1:0] act_stop
);
    localparam logic [CNT_W-1:0] POS_MAX = '1;

    AST_SYNC_CLEARS_POS: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_i |=> (bit_pos == '0));                                        // R1
    AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (act_start > act_stop) |-> !win_o);                                  // R3
    AST_STROBE_AFTER_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        win_o |=> (rx_strobe_o && (rx_data_o == $past(rxd_i))));             // R4
    AST_NO_STROBE_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !win_o |=> !rx_strobe_o);                                            // R4
    AST_TX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !win_o |-> txd_o);                                                   // R5
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fsync_i |=> ($stable(act_start) && $stable(act_stop)));             // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((bit_pos == POS_MAX) && !fsync_i) |=> !win_o);                      // R7
endmodule

bind tdm_slot_assigner tsa_checker #(.CNT_W(CNT_W)) u_tsa_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fsync_i     (fsync_i),
    .rxd_i       (rxd_i),
    .txd_o       (txd_o),
    .win_o       (win_o),
    .rx_data_o   (rx_data_o),
    .rx_strobe_o (rx_strobe_o),
    .bit_pos     (bit_pos),
    .act_start   (act_start),
    .act_stop    (act_stop)
);

// File: tb/tb_tdm_slot_assigner.sv
// Bench: exhaustive start/stop sweep on a 32-bit frame, plus saturation, early sync and reset cases.
module tb_tdm_slot_assigner;
    localparam int SLOT_W    = 8;
    localparam int NUM_SLOTS = 4;
    localparam int CW        = $clog2(SLOT_W * NUM_SLOTS);
    localparam int FRAME     = SLOT_W * NUM_SLOTS;
    localparam int PMAX      = FRAME - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fsync = 1'b0;
    logic          rxd = 1'b0;
    logic          txd, txd_oe;
    logic [CW-1:0] cfg_s = '0;
    logic [CW-1:0] cfg_e = '0;
    logic          tx_bit = 1'b0;
    logic          rx_data, rx_strobe, win;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string tag = "R8";

    always #4 clk = ~clk;  // 125 MHz

    tdm_slot_assigner #(.SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)) dut (
        .clk(clk), .rst_n(rst_n), .fsync_i(fsync), .rxd_i(rxd),
        .txd_o(txd), .txd_oe_o(txd_oe), .cfg_start_i(cfg_s), .cfg_stop_i(cfg_e),
        .tx_data_i(tx_bit), .rx_data_o(rx_data), .rx_strobe_o(rx_strobe), .win_o(win)
    );

    // Requirement model: position, liveness, working bounds.
    int m_pos = PMAX;
    bit m_live = 1'b0;
    int m_s = PMAX;
    int m_e = 0;
    bit m_win = 1'b0;
    bit e_strobe = 1'b0;
    bit e_data = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            e_strobe = 1'b0;
            m_pos = PMAX; m_live = 1'b0; m_s = PMAX; m_e = 0;
        end else begin
            e_strobe = m_win;
            if (m_win) e_data = rxd;
            if (fsync) begin
                m_pos = 0; m_live = 1'b1; m_s = int'(cfg_s); m_e = int'(cfg_e);
            end else if (m_pos == PMAX) begin
                m_live = 1'b0;
            end else begin
                m_pos++;
            end
        end
        m_win = m_live && (m_s <= m_pos) && (m_pos <= m_e);
        #2;
        if (!done) compare();
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s pos=%0d s=%0d e=%0d actual=%b expected=%b",
                     req, m_pos, m_s, m_e, act, exp);
        end
    endtask

    task automatic compare();
        chk(tag, win, m_win);                    // R2 / R3 / R6 / R7 / R8 / R9 / R10 by phase
        chk("R5", txd_oe, m_win);
        chk("R5", txd, m_win ? tx_bit : 1'b1);
        chk("R4", rx_strobe, e_strobe);
        if (e_strobe) chk("R4", rx_data, e_data);
    endtask

    // One frame: sync with the given bounds, then random config noise (R6).
    task automatic run_frame(input int s, input int e, input int len);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            fsync  = (k == 0);
            cfg_s  = (k == 0) ? CW'(s) : CW'($urandom);
            cfg_e  = (k == 0) ? CW'(e) : CW'($urandom);
            rxd    = 1'($urandom);
            tx_bit = 1'($urandom);
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            fsync = 1'b0; cfg_s = '0; cfg_e = CW'(PMAX);
            rxd = 1'($urandom); tx_bit = 1'($urandom);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        // R8: reset, then no sync with a full-frame config.
        tag = "R8";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle_cycles(40);
        // R1/R2/R3/R6/R10: every start/stop pair, one 32-bit frame each.
        for (int s = 0; s < FRAME; s++) begin
            for (int e = 0; e < FRAME; e++) begin
                tag = (s > e) ? "R3" : ((e / SLOT_W == s / SLOT_W) ? "R10" : "R2");
                run_frame(s, e, FRAME);
            end
        end
        // R9: early sync cuts a window that would run past it.
        tag = "R9";
        run_frame(15, 25, 20);
        run_frame(3, 31, 7);
        run_frame(0, 31, FRAME);
        run_frame(17, 19, 12);
        // R7: last position passes with no sync; window stays closed.
        tag = "R7";
        run_frame(0, 31, 1);
        idle_cycles(100);
        // R6: a sync after the idle run reopens with new bounds.
        tag = "R6";
        run_frame(5, 5, FRAME);
        run_frame(30, 31, FRAME);
        idle_cycles(4);
        finish_up();
    end

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        finish_up();
    end
endmodule